// File: doc/BRIEF.md
# Three-Port Integer Register File with Constant-Zero Entry

This block is the general-purpose register storage of a small 32-bit load/store processor core. An instruction names up to three registers with 5-bit numbers: two sources and one destination. The file returns both source values in the same cycle and can take one result back on each rising clock edge. Both read ports are combinational, so the decode stage sees each stored value directly. The write port is registered.

Entry 0 is not storage. It always reads as zero, and a write addressed to it is dropped without any effect. Software can therefore use it as a zero source or as a destination for discarded results. When a register is read and written in the same cycle, the read returns the value held before the edge. Any bypass of the new value belongs to the surrounding pipeline. A synchronous active-low reset clears every entry.

Top module: `rf_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, every entry is cleared, so after that edge both read ports return 0 for any selector.
- R2: With `wr_en` high at a rising edge and `wr_sel` not 0, entry `wr_sel` takes `wr_data`, and a read of that entry shows it from that edge onward.
- R3: With `wr_en` low at a rising edge, no entry changes.
- R4: A selector value of 0 on either read port returns 32'h0000_0000 at all times, even after a write of a nonzero value addressed to entry 0.
- R5: The two read ports are independent: each port returns the entry named by its own selector in the same cycle, including when both selectors name the same entry.
- R6: A read of the entry that is being written in the current cycle returns the value stored before the edge. The new value appears only after the edge.
- R7: When reset and a write are both active at the same edge, reset wins and the entry ends at 0.
- R8: A write changes only the entry it addresses. The other 30 storage entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears every entry |
| wr_en | input | 1 | Write enable for the destination port |
| wr_sel | input | 5 | Destination register number |
| wr_data | input | 32 | Value to be written |
| rd_a_sel | input | 5 | First source register number |
| rd_a_data | output | 32 | Value of the entry named by `rd_a_sel` |
| rd_b_sel | input | 5 | Second source register number |
| rd_b_data | output | 32 | Value of the entry named by `rd_b_sel` |

## Verification
The file is first filled in a sweep with a distinct pattern in every entry, then read back with both ports in opposite orders. Any swap of selector bits, or a write landing in a neighbouring entry, shows up as a wrong pattern on one of the ports. Directed cycles then cover the following cases:
- A write of all ones addressed to entry 0.
- A disabled write.
- A read of the entry being written in the same cycle, which tells the old value from the new one.
- A reset during a write.

Finally, a long pseudo-random stretch mixes writes, selectors and occasional resets. A per-cycle reference model compares both ports against the stored state every cycle.

// File: rtl/rf_pkg.sv
// Package: rf_pkg
// Shared constants for the register file. The defaults describe a 32-entry,
// 32-bit integer register file. Every module takes these as parameters.
package rf_pkg;
    localparam int unsigned RF_ENTRIES_DEF = 32;
    localparam int unsigned RF_WORD_W_DEF  = 32;
endpackage

// File: rtl/rf_wr_decode.sv
// Module: rf_wr_decode
// Turns the destination number and the write enable into one enable line per
// entry. Entry 0 never gets an enable, which is how writes to it vanish.
// Assumes ENTRIES <= 2**SEL_W. Out-of-range numbers enable nothing.
module rf_wr_decode #(
    parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES_DEF,
    parameter int unsigned SEL_W   = $clog2(ENTRIES)
) (
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    output logic [ENTRIES-1:0] we_vec
);
    // Entry 0 is tied off; the others compare against their own number.
    assign we_vec[0] = 1'b0;
    for (genvar i = 1; i < ENTRIES; i++) begin : g_dec
        assign we_vec[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    // R8: at most one entry is enabled per cycle, and never entry 0
    always_comb begin
        p_single_enable_r8: assert ($onehot0(we_vec) && !we_vec[0]);
    end
endmodule

// File: rtl/rf_word.sv
// Module: rf_word
// One storage entry. Synchronous active-low clear, then a load when enabled.
// Assumes the enable comes from rf_wr_decode, so it is one-hot across entries.
module rf_word #(
    parameter int unsigned WORD_W = rf_pkg::RF_WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Hold state; reset takes priority over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// A combinational read multiplexer over the flattened entry bus. A number
// that matches no entry returns zero.
// Assumes entry i sits at bits [i*WORD_W +: WORD_W] of the bus.
module rf_read_port #(
    parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES_DEF,
    parameter int unsigned WORD_W  = rf_pkg::RF_WORD_W_DEF,
    parameter int unsigned SEL_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES*WORD_W-1:0] entries_flat,
    input  logic [SEL_W-1:0]          sel,
    output logic [WORD_W-1:0]         data
);
    // Choose the one entry whose number matches the selector.
    always_comb begin
        data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel == SEL_W'(i))
                data = entries_flat[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/rf_core.sv
// Module: rf_core
// Top of the register file: two combinational source ports and one clocked
// destination port. Entry 0 is the constant zero. A read in the same cycle
// as a write sees the old value; any bypass is the pipeline's job.
// Assumes one clock domain and a synchronous active-low reset.
module rf_core #(
    parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES_DEF,
    parameter int unsigned WORD_W  = rf_pkg::RF_WORD_W_DEF,
    localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [WORD_W-1:0] rd_b_data
);
    logic [ENTRIES-1:0]        we_vec;
    logic [ENTRIES*WORD_W-1:0] entries_flat;

    // Destination decode: one enable line per entry.
    rf_wr_decode #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_dec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .we_vec (we_vec)
    );

    // Storage: entry 0 is a constant, the others are registers.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign entries_flat[WORD_W-1:0] = '0;
        end else begin : g_reg
            rf_word #(.WORD_W(WORD_W)) u_word (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_vec[i]),
                .d     (wr_data),
                .q     (entries_flat[i*WORD_W +: WORD_W])
            );
        end
    end

    // Source port A.
    rf_read_port #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_rd_a (
        .entries_flat (entries_flat),
        .sel          (rd_a_sel),
        .data         (rd_a_data)
    );

    // Source port B.
    rf_read_port #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_rd_b (
        .entries_flat (entries_flat),
        .sel          (rd_b_sel),
        .data         (rd_b_data)
    );

    // R4: the zero entry reads as zero on port A
    p_zero_port_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == '0) |-> (rd_a_data == '0));

    // R4: the zero entry reads as zero on port B
    p_zero_port_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == '0) |-> (rd_b_data == '0));

    // R2: a write to a nonzero entry is visible on port A one edge later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0 && rd_a_sel == wr_sel)
        |=> (rd_a_sel != $past(rd_a_sel)) || (rd_a_data == $past(wr_data)));

    // R3: with no write, a steady selector sees a steady value on port B
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($changed(rd_b_sel) || $stable(rd_b_data)));
endmodule

// File: tb/sim_rf_core.sv
// Bench for rf_core. A behavioural array model is updated at each rising
// edge and compared with both read ports every cycle, away from the edge.
module sim_rf_core;
    localparam int  NREG = 32;
    localparam time TCK  = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_sel;
    logic [31:0] wr_data;
    logic [4:0]  rd_a_sel;
    logic [4:0]  rd_b_sel;
    logic [31:0] rd_a_data;
    logic [31:0] rd_b_data;

    int          checks   = 0;
    int          failures = 0;
    bit          done     = 0;
    logic [31:0] model [NREG];
    logic [31:0] seed     = 32'h1234_5678;

    rf_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_a_sel  (rd_a_sel),
        .rd_a_data (rd_a_data),
        .rd_b_sel  (rd_b_sel),
        .rd_b_data (rd_b_data)
    );

    always #(TCK/2) clk = ~clk;

    // Compare one value and record the result.
    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // One cycle: drive after the falling edge, check both ports
    // combinationally against the model (pre-edge state), then update the
    // model at the rising edge.
    task automatic step(input string tag, input logic rn, input logic we,
                        input logic [4:0] ws, input logic [31:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        rst_n = rn; wr_en = we; wr_sel = ws; wr_data = wd;
        rd_a_sel = ra; rd_b_sel = rb;
        #1;
        check(tag, $sformatf("portA sel=%0d", ra), rd_a_data, model[ra]);
        check(tag, $sformatf("portB sel=%0d", rb), rd_b_data, model[rb]);
        @(posedge clk);
        if (!rn) begin
            for (int i = 0; i < NREG; i++) model[i] = '0;
        end else if (we && ws != 5'd0) begin
            model[ws] = wd;
        end
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // The model starts unknown; the reset cycles clear it.
        for (int i = 0; i < NREG; i++) model[i] = 'x;
        model[0] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_a_sel = '0; rd_b_sel = '0;
        @(posedge clk);
        for (int i = 0; i < NREG; i++) model[i] = '0;
        step("R1", 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd1);

        // R1: after reset every entry reads zero on both ports
        for (int i = 0; i < NREG; i++)
            step("R1", 1'b1, 1'b0, 5'd0, 32'h0, 5'(i), 5'(NREG-1-i));

        // R2/R8: fill every entry with a distinct pattern
        for (int i = 0; i < NREG; i++)
            step("R2", 1'b1, 1'b1, 5'(i), 32'hA5000000 | (32'(i) << 8) | 32'(i),
                 5'(i), 5'((i + 1) % NREG));

        // R5/R8: read back in opposite orders on the two ports
        for (int i = 0; i < NREG; i++)
            step("R5", 1'b1, 1'b0, 5'd3, 32'hDEAD_BEEF, 5'(i), 5'(NREG-1-i));
        step("R5", 1'b1, 1'b0, 5'd0, 32'h0, 5'd17, 5'd17);

        // R4: a write of all ones to entry 0 must leave it reading zero
        step("R4", 1'b1, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
        step("R4", 1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
        step("R4", 1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd1);

        // R3: a disabled write leaves the addressed entry unchanged
        step("R3", 1'b1, 1'b0, 5'd9, 32'h1357_9BDF, 5'd9, 5'd9);
        step("R3", 1'b1, 1'b0, 5'd9, 32'h0, 5'd9, 5'd9);

        // R6: a same-cycle read sees the old value, then the new one
        step("R6", 1'b1, 1'b1, 5'd12, 32'h0BAD_F00D, 5'd12, 5'd12);
        step("R6", 1'b1, 1'b0, 5'd0, 32'h0, 5'd12, 5'd12);

        // R7: reset beats a simultaneous write
        step("R7", 1'b0, 1'b1, 5'd20, 32'hCAFE_CAFE, 5'd20, 5'd12);
        step("R7", 1'b1, 1'b0, 5'd0, 32'h0, 5'd20, 5'd12);

        // Mixed stretch: random writes, selectors and rare resets
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = next_rand();
            step("R8", (r[31:26] != 6'd0), r[25], r[24:20], next_rand(),
                 r[19:15], r[14:10]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule